// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Unlock Key

This block is a watchdog timer peripheral reached through a small byte-addressed register window of 64 bytes. Software loads two preload values and a configuration, then enables the countdown. The countdown runs in two stages. Stage one counts down from the first preload. When it passes zero, stage two is loaded from the second preload. When stage two passes zero, the block raises a reset request and a timeout output, each only if its enable bit is set, and it always sets a sticky timeout flag. Software keeps the system alive by issuing the reload command before stage two expires. The reload command restarts stage one from the first preload.

Writes to the preload registers and to the reload/status register are protected. Each such write must follow an unlock key. The key is two byte writes to the key offset: 0x80 and then 0x86. The unlock is spent on the next protected write, whether that write is accepted or not. The lock bit is separate. Once set, it freezes the configuration, the preloads and the lock register until power-on reset. Reload commands still work while it is set.

The block has two resets. `por_n` clears everything, including the timeout flag and the lock register. `rst_n` is the system reset that the watchdog itself requests. It clears the unlock sequencer, the countdown, the preloads and the configuration. It leaves the timeout flag and the lock register intact, so software can see after the reset that the watchdog caused it.

Top module: `wdt_twostage`

## Requirements
- R1: After power-on reset, all of the following read as zero: the down counter (offset 0x14), the status byte (0x0D), the configuration (0x10), the lock register (0x18) and both preloads (0x00, 0x04). `rst_req` and `tmo_out` are low.
- R2: A write of 0x80 and then 0x86 to offset 0x0C opens the block for exactly one protected write. Protected writes go to 0x00, 0x04 or 0x0D. A second protected write after that one, with no new key, is ignored.
- R3: Any write to 0x0C that is not the expected next key byte returns the sequencer to idle. A write of 0x80 always restarts the key. A protected write made without a complete key has no effect.
- R4: The configuration register (0x10) and the lock register (0x18) need no key. They are written directly while the lock bit is clear.
- R5: Each count takes 2^SLOW_SHIFT clock cycles when configuration bit 2 is 0, and 2^FAST_SHIFT cycles when it is 1. With preloads P1 and P2, the flag sets (P1+P2+2) counts after a reload command. It sets one cycle later than that when the countdown is started by setting lock-register bit 1.
- R6: Offset 0x14 reads the count of the current stage. A first preload of 0 ends stage one at the first count, after which 0x14 shows the second preload.
- R7: Writing 1 to bit 0 of 0x0D, under a key, restarts stage one from the first preload at once and clears `tmo_out`.
- R8: On expiry, `rst_req` pulses for exactly one cycle if configuration bit 4 is set. `tmo_out` rises and stays high until a reload or a disable, if configuration bit 5 is set. `rst_cold` always mirrors configuration bit 3.
- R9: The timeout flag (bit 1 of 0x0D) is kept through `rst_n`. It is cleared only by writing 1 to it under a key, or by `por_n`.
- R10: Lock-register bit 0 is the lock. While it is set, writes to 0x10, 0x00, 0x04 and 0x18 are ignored, even under a key. Reload commands still act. Only `por_n` clears the lock.
- R11: Clearing lock-register bit 1 stops the countdown. The down counter then holds its value and no expiry occurs.
- R12: When lock-register bit 2 is set, expiry restarts stage one instead of halting, so expiries repeat every (P1+P2+2) counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and register clock |
| por_n | input | 1 | Power-on reset, active low; clears all state |
| rst_n | input | 1 | System reset, active low; keeps the flag and the lock register |
| wr_en | input | 1 | Register write strobe, one access per cycle |
| addr | input | 6 | Byte offset within the 64-byte window |
| wdata | input | 32 | Write data; key and status writes use bits 7:0 |
| rdata | output | 32 | Read data for `addr`, combinational |
| rst_req | output | 1 | One-cycle reset request on expiry |
| rst_cold | output | 1 | Requested reset type, 1 = cold |
| tmo_out | output | 1 | Timeout level output |

## Verification
A prescaler or stage-switch fault shows at the ports as an expiry that arrives a whole count early or late. The bench measures this to the exact cycle on every timed trial. A sequencer stuck open or stuck idle shows at once, in the next read-back of a preload that was written without a key or with a broken key. A flag or lock held in the wrong reset domain shows in the first status or lock read after `rst_n`. A frozen-register fault shows in the first configuration read after a write made while locked.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_PL1  = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_PL2  = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_KEY  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_STAT = 6'h0D;
    localparam logic [ADDR_W-1:0] OFF_CFG  = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_CNT  = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_LOCK = 6'h18;

    localparam logic [7:0] KEY_FIRST  = 8'h80;
    localparam logic [7:0] KEY_SECOND = 8'h86;

    typedef enum logic [1:0] {
        U_IDLE,
        U_KEY1,
        U_OPEN
    } unlock_e;

    typedef enum logic [1:0] {
        T_OFF,
        T_ST1,
        T_ST2,
        T_DONE
    } tstate_e;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    input  logic       prot_wr,
    output logic       open
);
    unlock_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= U_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (key_wr) begin
            if (key_byte == KEY_FIRST)
                st_d = U_KEY1;
            else if (st_q == U_KEY1 && key_byte == KEY_SECOND)
                st_d = U_OPEN;
            else
                st_d = U_IDLE;
        end else if (prot_wr && st_q == U_OPEN) begin
            st_d = U_IDLE;
        end
    end

    assign open = (st_q == U_OPEN);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int SLOW_SHIFT = 15,
    parameter int FAST_SHIFT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             reload,
    input  logic             fast_sel,
    input  logic             periodic,
    input  logic [CNT_W-1:0] pl1,
    input  logic [CNT_W-1:0] pl2,
    output logic [CNT_W-1:0] cnt,
    output logic             fire
);
    localparam logic [SLOW_SHIFT-1:0] SLOW_MASK = '1;
    localparam logic [SLOW_SHIFT-1:0] FAST_MASK =
        {{(SLOW_SHIFT-FAST_SHIFT){1'b0}}, {FAST_SHIFT{1'b1}}};

    tstate_e               st_q, st_d;
    logic [CNT_W-1:0]      cnt_q, cnt_d;
    logic [SLOW_SHIFT-1:0] presc_q, presc_d;
    logic                  tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= T_OFF;
            cnt_q   <= '0;
            presc_q <= '0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            presc_q <= presc_d;
        end
    end

    always_comb begin
        if (fast_sel) tick = ((presc_q & FAST_MASK) == FAST_MASK);
        else          tick = (presc_q == SLOW_MASK);
    end

    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        presc_d = presc_q;
        fire    = 1'b0;
        if (!en) begin
            st_d    = T_OFF;
            presc_d = '0;
            if (reload) cnt_d = pl1;
        end else if (reload || st_q == T_OFF) begin
            st_d    = T_ST1;
            cnt_d   = pl1;
            presc_d = '0;
        end else begin
            unique case (st_q)
                T_ST1: begin
                    presc_d = presc_q + 1'b1;
                    if (tick) begin
                        if (cnt_q == '0) begin
                            st_d  = T_ST2;
                            cnt_d = pl2;
                        end else begin
                            cnt_d = cnt_q - 1'b1;
                        end
                    end
                end
                T_ST2: begin
                    presc_d = presc_q + 1'b1;
                    if (tick) begin
                        if (cnt_q == '0) begin
                            fire = 1'b1;
                            if (periodic) begin
                                st_d  = T_ST1;
                                cnt_d = pl1;
                            end else begin
                                st_d = T_DONE;
                            end
                        end else begin
                            cnt_d = cnt_q - 1'b1;
                        end
                    end
                end
                T_DONE: st_d = T_DONE;
                T_OFF:  st_d = T_ST1;
                default: st_d = T_OFF;
            endcase
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/wdt_twostage.sv
module wdt_twostage
    import wdt_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int SLOW_SHIFT = 15,
    parameter int FAST_SHIFT = 5
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rst_req,
    output logic              rst_cold,
    output logic              tmo_out
);
    logic             sys_rst_n;
    logic             wr_pl1, wr_pl2, wr_stat, wr_cfg, wr_lock, key_wr;
    logic             prot_wr, prot_go, ul_open;
    logic             reload_go, flag_clr, fire;
    logic [CNT_W-1:0] pl1_q, pl2_q, cnt;
    logic [5:2]       cfg_q;
    logic             lock_q, en_q, periodic_q;
    logic             flag_q, tmo_q;

    assign sys_rst_n = rst_n & por_n;

    assign key_wr  = wr_en && addr == OFF_KEY;
    assign wr_pl1  = wr_en && addr == OFF_PL1;
    assign wr_pl2  = wr_en && addr == OFF_PL2;
    assign wr_stat = wr_en && addr == OFF_STAT;
    assign wr_cfg  = wr_en && addr == OFF_CFG;
    assign wr_lock = wr_en && addr == OFF_LOCK;

    assign prot_wr   = wr_pl1 | wr_pl2 | wr_stat;
    assign prot_go   = prot_wr && ul_open;
    assign reload_go = prot_go && wr_stat && wdata[0];
    assign flag_clr  = prot_go && wr_stat && wdata[1];

    wdt_unlock u_unlock (
        .clk      (clk),
        .rst_n    (sys_rst_n),
        .key_wr   (key_wr),
        .key_byte (wdata[7:0]),
        .prot_wr  (prot_wr),
        .open     (ul_open)
    );

    wdt_core #(
        .CNT_W      (CNT_W),
        .SLOW_SHIFT (SLOW_SHIFT),
        .FAST_SHIFT (FAST_SHIFT)
    ) u_core (
        .clk      (clk),
        .rst_n    (sys_rst_n),
        .en       (en_q),
        .reload   (reload_go),
        .fast_sel (cfg_q[2]),
        .periodic (periodic_q),
        .pl1      (pl1_q),
        .pl2      (pl2_q),
        .cnt      (cnt),
        .fire     (fire)
    );

    // Preloads and configuration: cleared by system reset
    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            pl1_q <= '0;
            pl2_q <= '0;
            cfg_q <= '0;
        end else begin
            if (prot_go && wr_pl1 && !lock_q) pl1_q <= wdata[CNT_W-1:0];
            if (prot_go && wr_pl2 && !lock_q) pl2_q <= wdata[CNT_W-1:0];
            if (wr_cfg && !lock_q)            cfg_q <= wdata[5:2];
        end
    end

    // Lock register and sticky flag: power-on reset only
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            lock_q     <= 1'b0;
            en_q       <= 1'b0;
            periodic_q <= 1'b0;
            flag_q     <= 1'b0;
        end else begin
            if (wr_lock && !lock_q) begin
                lock_q     <= wdata[0];
                en_q       <= wdata[1];
                periodic_q <= wdata[2];
            end
            if (fire)          flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    // Expiry outputs
    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            rst_req <= 1'b0;
            tmo_q   <= 1'b0;
        end else begin
            rst_req <= fire && cfg_q[4];
            if (fire && cfg_q[5])          tmo_q <= 1'b1;
            else if (reload_go || !en_q)   tmo_q <= 1'b0;
        end
    end

    assign tmo_out  = tmo_q;
    assign rst_cold = cfg_q[3];

    always_comb begin
        rdata = '0;
        case (addr)
            OFF_PL1:  rdata = DATA_W'(pl1_q);
            OFF_PL2:  rdata = DATA_W'(pl2_q);
            OFF_STAT: rdata = {30'd0, flag_q, 1'b0};
            OFF_CFG:  rdata = {26'd0, cfg_q, 2'b00};
            OFF_CNT:  rdata = DATA_W'(cnt);
            OFF_LOCK: rdata = {29'd0, periodic_q, en_q, lock_q};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_twostage_chk.sv
module wdt_twostage_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             por_n,
    input logic             rst_n,
    input logic             rst_req,
    input logic             flag_q,
    input logic             lock_q,
    input logic [5:2]       cfg_q,
    input logic             en_q,
    input logic             reload_go,
    input logic             prot_go,
    input logic             ul_open,
    input logic [CNT_W-1:0] cnt
);
    // R8: reset request is a single-cycle pulse
    a_r8_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        rst_req |=> !rst_req);

    // R8: reset request only when its enable bit was set
    a_r8_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        rst_req |-> $past(cfg_q[4]));

    // R9: flag sets only at a stage-two expiry (counter at zero)
    a_r9_flag_on_expiry: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        $rose(flag_q) |-> $past(cnt == '0));

    // R2: an accepted protected write spends the unlock
    a_r2_unlock_spent: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        prot_go |=> !ul_open);

    // R10: configuration frozen while locked
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        lock_q |=> $stable(cfg_q));

    // R11: counter holds while disabled
    a_r11_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (!en_q && !reload_go) |=> $stable(cnt));
endmodule

bind wdt_twostage wdt_twostage_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .rst_req   (rst_req),
    .flag_q    (flag_q),
    .lock_q    (lock_q),
    .cfg_q     (cfg_q),
    .en_q      (en_q),
    .reload_go (reload_go),
    .prot_go   (prot_go),
    .ul_open   (ul_open),
    .cnt       (cnt)
);

// File: tb/wdt_twostage_test.sv
`timescale 1ns/1ps
module wdt_twostage_test;
    localparam int SLOW = 4;
    localparam int FAST = 2;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_req, rst_cold, tmo_out;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    wdt_twostage #(.CNT_W(32), .SLOW_SHIFT(SLOW), .FAST_SHIFT(FAST)) uut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rst_req(rst_req), .rst_cold(rst_cold),
        .tmo_out(tmo_out)
    );

    function automatic int exp_cycles(int p1, int p2, bit fast, bit via_en);
        return (p1 + p2 + 2) * (fast ? (1 << FAST) : (1 << SLOW)) + (via_en ? 1 : 0);
    endfunction

    task automatic chk(string req, longint got, longint exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic unlock();
        wr(6'h0C, 32'h80);
        wr(6'h0C, 32'h86);
    endtask

    task automatic power_on();
        por_n = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, c1, c2;
        int n, pulses;
        void'($urandom(32'd2024));
        power_on();

        // R1: reset state
        rd(6'h14, v); chk("R1 counter", v, 0);
        rd(6'h0D, v); chk("R1 status", v, 0);
        rd(6'h10, v); chk("R1 config", v, 0);
        rd(6'h18, v); chk("R1 lock", v, 0);
        rd(6'h00, v); chk("R1 preload1", v, 0);
        chk("R1 rst_req", rst_req, 0);
        chk("R1 tmo_out", tmo_out, 0);

        // R2: key opens one protected write
        unlock(); wr(6'h00, 32'd5);
        rd(6'h00, v); chk("R2 preload1 accepted", v, 5);
        wr(6'h04, 32'd7);
        rd(6'h04, v); chk("R2 second write ignored", v, 0);

        // R3: broken key, restarted key
        wr(6'h0C, 32'h80); wr(6'h0C, 32'h55); wr(6'h0C, 32'h86); wr(6'h04, 32'd9);
        rd(6'h04, v); chk("R3 broken key ignored", v, 0);
        wr(6'h0C, 32'h80); wr(6'h0C, 32'h80); wr(6'h0C, 32'h86); wr(6'h04, 32'd3);
        rd(6'h04, v); chk("R3 restarted key", v, 3);

        // R4: direct config write
        wr(6'h10, 32'h3C);
        rd(6'h10, v); chk("R4 config direct", v, 32'h3C);
        wr(6'h10, 32'h00);

        // R6 / R7: counter read-back after reload
        wr(6'h18, 32'h2);
        unlock(); wr(6'h0D, 32'h1);
        rd(6'h14, v); chk("R7 reload loads preload1", v, 5);
        repeat (1 << SLOW) @(negedge clk);
        rd(6'h14, v); chk("R6 one count down", v, 4);

        // R6: zero first preload ends stage one at first count
        wr(6'h18, 32'h0);
        unlock(); wr(6'h00, 32'd0);
        wr(6'h18, 32'h2);
        repeat ((1 << SLOW) + 1) @(negedge clk);
        rd(6'h14, v); chk("R6 zero preload to stage two", v, 3);

        // R5 / R8 / R7: timed random trials
        for (int t = 0; t < 8; t++) begin
            int p1, p2;
            bit fast, ren, ten, cold, via_en;
            p1 = $urandom_range(0, 4); p2 = $urandom_range(0, 4);
            fast = 1'($urandom_range(0, 1)); ren = 1'($urandom_range(0, 1));
            ten = 1'($urandom_range(0, 1)); cold = 1'($urandom_range(0, 1));
            via_en = 1'($urandom_range(0, 1));
            if (t == 0) begin p1 = 0; p2 = 0; fast = 1; ren = 1; ten = 1; end
            wr(6'h18, 32'h0);
            unlock(); wr(6'h0D, 32'h2);
            unlock(); wr(6'h00, 32'(p1));
            unlock(); wr(6'h04, 32'(p2));
            wr(6'h10, {26'd0, ten, ren, cold, fast, 2'b00});
            wr(6'h18, 32'h2);
            if (!via_en) begin
                wr(6'h0C, 32'h80);
                wr(6'h0C, 32'h86);
                wr(6'h0D, 32'h1);
            end
            n = 0;
            rd(6'h0D, v);
            while (v[1] == 1'b0 && n < 3000) begin
                @(negedge clk); n++; rd(6'h0D, v);
            end
            chk("R5 expiry cycle", n, exp_cycles(p1, p2, fast, via_en));
            chk("R8 rst_req on expiry", rst_req, ren);
            chk("R8 tmo_out on expiry", tmo_out, ten);
            chk("R8 rst_cold mirrors config", rst_cold, cold);
            @(negedge clk);
            chk("R8 rst_req one cycle", rst_req, 0);
            chk("R8 tmo_out held", tmo_out, ten);
            unlock(); wr(6'h0D, 32'h1);
            chk("R7 reload clears tmo_out", tmo_out, 0);
        end

        // R9: flag survives system reset
        wr(6'h18, 32'h0);
        rd(6'h0D, v); chk("R9 flag set before reset", v[1], 1);
        rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1; @(negedge clk);
        rd(6'h0D, v); chk("R9 flag kept through rst_n", v[1], 1);
        rd(6'h10, v); chk("R9 config cleared by rst_n", v, 0);
        wr(6'h0D, 32'h2);
        rd(6'h0D, v); chk("R9 clear without key ignored", v[1], 1);
        unlock(); wr(6'h0D, 32'h2);
        rd(6'h0D, v); chk("R9 clear with key", v[1], 0);

        // R12: periodic expiry
        unlock(); wr(6'h00, 32'd1);
        unlock(); wr(6'h04, 32'd1);
        wr(6'h10, 32'h14);
        wr(6'h18, 32'h6);
        pulses = 0;
        for (int k = 1; k <= 100; k++) begin
            @(negedge clk);
            if (rst_req) pulses++;
        end
        chk("R12 periodic pulse count", pulses, 6);
        wr(6'h18, 32'h0);

        // R11: disable holds the counter
        unlock(); wr(6'h00, 32'd20);
        wr(6'h10, 32'h0);
        wr(6'h18, 32'h2);
        repeat (40) @(negedge clk);
        wr(6'h18, 32'h0);
        rd(6'h14, c1);
        repeat (100) @(negedge clk);
        rd(6'h14, c2);
        chk("R11 counter held", c2, c1);
        chk("R11 counter moved before stop", (c1 < 20) ? 1 : 0, 1);

        // R10: lock freezes registers, reload still works
        wr(6'h10, 32'h04);
        wr(6'h18, 32'h3);
        wr(6'h10, 32'h20);
        rd(6'h10, v); chk("R10 config frozen", v, 32'h04);
        unlock(); wr(6'h00, 32'd99);
        rd(6'h00, v); chk("R10 preload frozen", v, 20);
        wr(6'h18, 32'h0);
        rd(6'h18, v); chk("R10 lock frozen", v, 3);
        rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1; @(negedge clk);
        rd(6'h18, v); chk("R10 lock kept through rst_n", v, 3);
        unlock(); wr(6'h00, 32'd12);
        rd(6'h00, v); chk("R10 preload frozen after rst_n", v, 0);
        unlock(); wr(6'h0D, 32'h1);
        rd(6'h14, v); chk("R10 reload under lock", v, 0);
        power_on();
        rd(6'h18, v); chk("R10 lock cleared by por_n", v, 0);
        rd(6'h0D, v); chk("R1 flag cleared by por_n", v, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule